// File: doc/BRIEF.md
# Eight-bit ALU with Flag Register

This block is the arithmetic and logic datapath of a small 8-bit processor core, together with the eight-bit flag register that it maintains. Each cycle in which `op_valid` is high, it takes two byte operands, an operation code and a three-bit bit index. It produces a result byte and a write-back strobe straight away, from logic alone. At the next clock edge it updates the flag register according to fixed rules for each flag. The operations are addition and subtraction, with and without the incoming carry, comparison, chained comparison, negation, bitwise logic, a zero/sign test, bit transfer between an operand bit and the T flag, setting and clearing the interrupt-enable flag, and branch-condition evaluation.

The flags drive two things: the carry and T inputs of the next operation, and the `branch_taken` output. For a branch operation, `branch_taken` reflects the flags as they stand in that cycle. Multi-byte arithmetic and comparison are built by issuing the carry-consuming operations byte after byte, low byte first. The chained zero rule makes the Z flag describe the whole multi-byte value. Instruction decode, operand fetch and the program counter are outside the block.

Top module: `alu8_flags`

## Requirements
- R1: The flag register holds, from bit 7 down to bit 0: I, T, H, S, V, N, Z, C. While `rst_n` is low, all eight bits read 0.
- R2: Code 1 (ADD) and code 2 (ADC, which adds C) give result = a + b (+C) mod 256 with `result_we`=1. C is the carry out of bit 7, H is the carry out of bit 3, and V is set on two's-complement overflow.
- R3: Code 3 (SUB) and code 4 (SBC, which subtracts C) give result = a - b (-C) mod 256. Code 7 (NEG) gives 0 - a. All three have `result_we`=1. C is set on an unsigned borrow, H is set when bit 3 borrows from bit 4, and V is set on two's-complement overflow.
- R4: After every update, S equals N xor V. N is bit 7 of the result.
- R5: Code 5 (CP) and code 6 (CPC) set the flags exactly as SUB and SBC would, and hold `result_we` at 0.
- R6: SBC and CPC clear Z when their result is nonzero and leave Z unchanged otherwise. ADD, ADC, SUB, CP and NEG set Z exactly when their result is zero.
- R7: Codes 8 to 10 (AND, OR, XOR of a and b) write their result. Code 11 (TST) evaluates a AND a and writes nothing. All four clear V, set N and Z from the result, and leave C and H unchanged.
- R8: Code 12 copies bit `bit_sel` of a into T and writes nothing. Code 13 writes a with bit `bit_sel` replaced by T. Neither changes any other flag.
- R9: Code 14 sets I and code 15 clears I. No other flag changes.
- R10: Codes 16 to 21 assert `branch_taken` when, respectively, S=0, S=1, C=0, C=1, Z=1 or Z=0. They leave the flags unchanged. `branch_taken` is 0 for any other code and whenever `op_valid` is low.
- R11: While `op_valid` is low, the flag register holds its value and `result_we` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Operation present this cycle |
| opcode | input | 5 | Operation code |
| opa | input | 8 | First operand (destination operand) |
| opb | input | 8 | Second operand |
| bit_sel | input | 3 | Bit index for the bit transfer operations |
| result | output | 8 | Result byte |
| result_we | output | 1 | Result is to be written back |
| status | output | 8 | Flag register |
| branch_taken | output | 1 | Branch condition holds |

## Verification
The arithmetic operations are swept over every value of a, paired with sixteen values of b spread across the range. This exposes carries and borrows at both the nibble and the byte boundary, and signed overflow in each direction. Each carry- or Z-consuming operation is preceded by a preset addition that leaves one of the four C/Z combinations. This separates the chained zero rule from the plain one, and a carry that is consumed from one that is ignored. Logic operations run after presets that set C, H and V, so clearing V is distinguished from preserving C and H. Every bit index is exercised for the bit transfers, and every branch condition is evaluated against flag patterns in which S differs from N.

// File: rtl/alu8_pkg.sv
package alu8_pkg;
  localparam int DW = 8;
  localparam int IW = $clog2(DW);
  localparam int NIB = 4;

  // flag positions
  localparam int F_I = 7;
  localparam int F_T = 6;
  localparam int F_H = 5;
  localparam int F_S = 4;
  localparam int F_V = 3;
  localparam int F_N = 2;
  localparam int F_Z = 1;
  localparam int F_C = 0;

  typedef enum logic [4:0] {
    OP_NOP = 5'd0,
    OP_ADD = 5'd1,
    OP_ADC = 5'd2,
    OP_SUB = 5'd3,
    OP_SBC = 5'd4,
    OP_CP  = 5'd5,
    OP_CPC = 5'd6,
    OP_NEG = 5'd7,
    OP_AND = 5'd8,
    OP_OR  = 5'd9,
    OP_XOR = 5'd10,
    OP_TST = 5'd11,
    OP_TSV = 5'd12,
    OP_TLD = 5'd13,
    OP_IEN = 5'd14,
    OP_IDS = 5'd15,
    OP_BGE = 5'd16,
    OP_BLT = 5'd17,
    OP_BSH = 5'd18,
    OP_BLO = 5'd19,
    OP_BEQ = 5'd20,
    OP_BNE = 5'd21
  } op_e;
endpackage

// File: rtl/alu8_addsub.sv
module alu8_addsub
  import alu8_pkg::*;
(
  input  logic [DW-1:0] x,
  input  logic [DW-1:0] y,
  input  logic          cin,
  input  logic          sub,
  output logic [DW-1:0] sum,
  output logic          c_out,
  output logic          h_out,
  output logic          v_out
);
  logic [DW:0]  full;
  logic [NIB:0] low;
  logic         xs, ys, rs;

  always_comb begin
    if (sub) begin
      full = {1'b0, x} - {1'b0, y} - {{DW{1'b0}}, cin};
      low  = {1'b0, x[NIB-1:0]} - {1'b0, y[NIB-1:0]} - {{NIB{1'b0}}, cin};
    end else begin
      full = {1'b0, x} + {1'b0, y} + {{DW{1'b0}}, cin};
      low  = {1'b0, x[NIB-1:0]} + {1'b0, y[NIB-1:0]} + {{NIB{1'b0}}, cin};
    end
    sum   = full[DW-1:0];
    c_out = full[DW];
    h_out = low[NIB];
    xs = x[DW-1];
    ys = y[DW-1];
    rs = sum[DW-1];
    if (sub) v_out = (xs & ~ys & ~rs) | (~xs & ys & rs);
    else     v_out = (xs & ys & ~rs) | (~xs & ~ys & rs);
  end
endmodule

// File: rtl/alu8_bitlogic.sv
module alu8_bitlogic
  import alu8_pkg::*;
(
  input  op_e           op,
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  logic          t_in,
  input  logic [IW-1:0] idx,
  output logic [DW-1:0] res
);
  always_comb begin
    res = a;
    unique case (op)
      OP_AND:  res = a & b;
      OP_OR:   res = a | b;
      OP_XOR:  res = a ^ b;
      OP_TST:  res = a & a;
      OP_TLD:  res[idx] = t_in;
      default: res = a;
    endcase
  end
endmodule

// File: rtl/alu8_branch.sv
module alu8_branch
  import alu8_pkg::*;
(
  input  op_e  op,
  input  logic valid,
  input  logic s_f,
  input  logic c_f,
  input  logic z_f,
  output logic taken
);
  logic cond;

  always_comb begin
    unique case (op)
      OP_BGE:  cond = ~s_f;
      OP_BLT:  cond = s_f;
      OP_BSH:  cond = ~c_f;
      OP_BLO:  cond = c_f;
      OP_BEQ:  cond = z_f;
      OP_BNE:  cond = ~z_f;
      default: cond = 1'b0;
    endcase
    taken = valid & cond;
  end
endmodule

// File: rtl/alu8_flags.sv
module alu8_flags
  import alu8_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          op_valid,
  input  logic [4:0]    opcode,
  input  logic [DW-1:0] opa,
  input  logic [DW-1:0] opb,
  input  logic [IW-1:0] bit_sel,
  output logic [DW-1:0] result,
  output logic          result_we,
  output logic [7:0]    status,
  output logic          branch_taken
);
  op_e           op;
  logic [1:0]    rst_sync;
  logic          rst_i_n;
  logic [7:0]    flags_q, flags_d;
  logic          flags_en;

  logic          is_sub, use_cin, chain_z;
  logic [DW-1:0] as_x, as_y, as_sum, lg_res;
  logic          as_c, as_h, as_v;

  assign op = op_e'(opcode);

  // reset: asserted at once, released two edges later
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_i_n = rst_sync[1];

  // operand steering for the shared adder-subtractor
  always_comb begin
    is_sub  = (op == OP_SUB) || (op == OP_SBC) || (op == OP_CP) ||
              (op == OP_CPC) || (op == OP_NEG);
    use_cin = (op == OP_ADC) || (op == OP_SBC) || (op == OP_CPC);
    chain_z = (op == OP_SBC) || (op == OP_CPC);
    as_x    = (op == OP_NEG) ? '0 : opa;
    as_y    = (op == OP_NEG) ? opa : opb;
  end

  alu8_addsub u_addsub (
    .x     (as_x),
    .y     (as_y),
    .cin   (use_cin & flags_q[F_C]),
    .sub   (is_sub),
    .sum   (as_sum),
    .c_out (as_c),
    .h_out (as_h),
    .v_out (as_v)
  );

  alu8_bitlogic u_bitlogic (
    .op   (op),
    .a    (opa),
    .b    (opb),
    .t_in (flags_q[F_T]),
    .idx  (bit_sel),
    .res  (lg_res)
  );

  alu8_branch u_branch (
    .op    (op),
    .valid (op_valid),
    .s_f   (flags_q[F_S]),
    .c_f   (flags_q[F_C]),
    .z_f   (flags_q[F_Z]),
    .taken (branch_taken)
  );

  // next flags and result
  always_comb begin
    flags_d   = flags_q;
    result    = opa;
    result_we = 1'b0;
    if (op_valid) begin
      unique case (op)
        OP_ADD, OP_ADC, OP_SUB, OP_SBC, OP_CP, OP_CPC, OP_NEG: begin
          result       = as_sum;
          result_we    = !((op == OP_CP) || (op == OP_CPC));
          flags_d[F_C] = as_c;
          flags_d[F_H] = as_h;
          flags_d[F_V] = as_v;
          flags_d[F_N] = as_sum[DW-1];
          flags_d[F_Z] = (as_sum == '0) & (chain_z ? flags_q[F_Z] : 1'b1);
          flags_d[F_S] = as_sum[DW-1] ^ as_v;
        end
        OP_AND, OP_OR, OP_XOR, OP_TST: begin
          result       = lg_res;
          result_we    = (op != OP_TST);
          flags_d[F_V] = 1'b0;
          flags_d[F_N] = lg_res[DW-1];
          flags_d[F_Z] = (lg_res == '0);
          flags_d[F_S] = lg_res[DW-1];
        end
        OP_TSV: flags_d[F_T] = opa[bit_sel];
        OP_TLD: begin
          result    = lg_res;
          result_we = 1'b1;
        end
        OP_IEN: flags_d[F_I] = 1'b1;
        OP_IDS: flags_d[F_I] = 1'b0;
        default: flags_d = flags_q;
      endcase
    end
  end

  assign flags_en = op_valid;

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n)      flags_q <= '0;
    else if (flags_en) flags_q <= flags_d;
  end

  assign status = flags_q;
endmodule

// File: rtl/alu8_flags_chk.sv
module alu8_flags_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       op_valid,
  input logic [4:0] opcode,
  input logic [7:0] opa,
  input logic [2:0] bit_sel,
  input logic       result_we,
  input logic [7:0] status,
  input logic       branch_taken
);
  logic sel_bit;
  assign sel_bit = opa[bit_sel];

  // R4
  sign_rule_chk: assert property (@(posedge clk) disable iff (!rst_n)
    status[4] == (status[2] ^ status[3]));

  // R5
  cmp_nowrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && (opcode == 5'd5 || opcode == 5'd6)) |-> !result_we);

  // R8
  tflag_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && opcode == 5'd12) |=> status[6] == $past(sel_bit));

  // R9
  ien_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && opcode == 5'd14) |=> status[7]);

  // R9
  ids_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && opcode == 5'd15) |=> !status[7]);

  // R10
  branch_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    branch_taken |-> op_valid);

  // R10
  branch_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && opcode >= 5'd16 && opcode <= 5'd21) |=> $stable(status));

  // R11
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |=> $stable(status));
endmodule

bind alu8_flags alu8_flags_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .op_valid     (op_valid),
  .opcode       (opcode),
  .opa          (opa),
  .bit_sel      (bit_sel),
  .result_we    (result_we),
  .status       (status),
  .branch_taken (branch_taken)
);

// File: tb/alu8_flags_bench.sv
`timescale 1ns/1ps
module alu8_flags_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b1;
  logic       op_valid = 1'b0;
  logic [4:0] opcode = '0;
  logic [7:0] opa = '0, opb = '0;
  logic [2:0] bit_sel = '0;
  logic [7:0] result, status;
  logic       result_we, branch_taken;

  int n_chk = 0, n_fail = 0;
  logic [7:0] m = '0;   // expected flag register

  always #2 clk = ~clk;

  alu8_flags u_alu8_flags (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .opcode(opcode),
    .opa(opa), .opb(opb), .bit_sel(bit_sel), .result(result),
    .result_we(result_we), .status(status), .branch_taken(branch_taken)
  );

  function automatic int sx(input logic [7:0] v);
    return v[7] ? int'(v) - 256 : int'(v);
  endfunction

  function automatic string tag(input int op);
    if (op == 1 || op == 2) return "R2";
    if (op == 3 || op == 4 || op == 7) return "R3";
    if (op == 5 || op == 6) return "R5";
    if (op >= 8 && op <= 11) return "R7";
    if (op == 12 || op == 13) return "R8";
    if (op == 14 || op == 15) return "R9";
    if (op >= 16 && op <= 21) return "R10";
    return "R11";
  endfunction

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic model(input int op, input logic [7:0] a, input logic [7:0] b,
                       input logic [2:0] idx, input logic [7:0] f,
                       output logic [7:0] r, output logic we,
                       output logic tk, output logic [7:0] fn);
    int u, su;
    logic [7:0] x, y;
    logic cin, nzs;
    fn = f; r = a; we = 1'b0; tk = 1'b0; nzs = 1'b0;
    cin = f[0] & (op == 2 || op == 4 || op == 6);
    if (op == 1 || op == 2) begin
      u = int'(a) + int'(b) + int'(cin);
      r = u[7:0]; we = 1'b1; nzs = 1'b1;
      fn[0] = (u > 255);
      fn[5] = (int'(a[3:0]) + int'(b[3:0]) + int'(cin)) > 15;
      su = sx(a) + sx(b) + int'(cin);
      fn[3] = (su > 127) || (su < -128);
      fn[1] = (r == 8'h00);
    end else if (op >= 3 && op <= 7) begin
      x = (op == 7) ? 8'h00 : a;
      y = (op == 7) ? a : b;
      u = int'(x) - int'(y) - int'(cin);
      r = u[7:0]; nzs = 1'b1;
      we = (op == 3 || op == 4 || op == 7);
      fn[0] = (u < 0);
      fn[5] = (int'(x[3:0]) - int'(y[3:0]) - int'(cin)) < 0;
      su = sx(x) - sx(y) - int'(cin);
      fn[3] = (su > 127) || (su < -128);
      fn[1] = (r == 8'h00) && ((op == 4 || op == 6) ? f[1] : 1'b1);
    end else if (op >= 8 && op <= 11) begin
      case (op)
        8: r = a & b;
        9: r = a | b;
        10: r = a ^ b;
        default: r = a;
      endcase
      we = (op != 11); nzs = 1'b1;
      fn[3] = 1'b0;
      fn[1] = (r == 8'h00);
    end else if (op == 12) begin
      fn[6] = a[idx];
    end else if (op == 13) begin
      r[idx] = f[6]; we = 1'b1;
    end else if (op == 14) begin
      fn[7] = 1'b1;
    end else if (op == 15) begin
      fn[7] = 1'b0;
    end else if (op >= 16 && op <= 21) begin
      case (op)
        16: tk = !f[4];
        17: tk = f[4];
        18: tk = !f[0];
        19: tk = f[0];
        20: tk = f[1];
        default: tk = !f[1];
      endcase
    end
    if (nzs) begin
      fn[2] = r[7];
      fn[4] = fn[2] ^ fn[3];
    end
  endtask

  task automatic do_op(input int op, input logic [7:0] a, input logic [7:0] b,
                       input logic [2:0] idx);
    logic [7:0] er, ef;
    logic ew, et;
    string t;
    model(op, a, b, idx, m, er, ew, et, ef);
    t = tag(op);
    @(negedge clk);
    op_valid = 1'b1; opcode = op[4:0]; opa = a; opb = b; bit_sel = idx;
    #1;
    chk(t, "result_we", {31'b0, result_we}, {31'b0, ew});
    if (ew) chk(t, "result", {24'b0, result}, {24'b0, er});
    chk(t, "branch_taken", {31'b0, branch_taken}, {31'b0, et});
    @(posedge clk);
    #1;
    chk(t, "status", {24'b0, status}, {24'b0, ef});
    chk("R4", "S vs N^V", {31'b0, status[4]}, {31'b0, status[2] ^ status[3]});
    if (op == 4 || op == 6) chk("R6", "chained Z", {31'b0, status[1]}, {31'b0, ef[1]});
    m = ef;
  endtask

  task automatic do_idle(input int op);
    @(negedge clk);
    op_valid = 1'b0; opcode = op[4:0]; opa = 8'hA5; opb = 8'h3C; bit_sel = 3'd2;
    #1;
    chk("R11", "idle result_we", {31'b0, result_we}, 32'd0);
    chk("R10", "idle branch_taken", {31'b0, branch_taken}, 32'd0);
    @(posedge clk);
    #1;
    chk("R11", "idle status", {24'b0, status}, {24'b0, m});
  endtask

  task automatic preset(input int p);
    case (p)
      0: do_op(1, 8'h00, 8'h00, 3'd0);   // Z=1 C=0
      1: do_op(1, 8'h01, 8'h00, 3'd0);   // Z=0 C=0
      2: do_op(1, 8'hFF, 8'h01, 3'd0);   // Z=1 C=1
      3: do_op(1, 8'hFF, 8'h02, 3'd0);   // Z=0 C=1
      4: do_op(1, 8'h0F, 8'h01, 3'd0);   // H=1
      5: do_op(1, 8'h88, 8'h88, 3'd0);   // C=1 H=1 V=1
      6: do_op(1, 8'h7F, 8'h01, 3'd0);   // V=1 N=1 S=0
      default: do_op(1, 8'h40, 8'h50, 3'd0); // N=1 V=1
    endcase
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #1 rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    chk("R1", "reset status", {24'b0, status}, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
    m = 8'h00;

    // R2 R3 R5 R6: arithmetic sweep with carry/zero presets
    for (int a = 0; a < 256; a++) begin
      for (int bi = 0; bi < 16; bi++) begin
        do_op(1, a[7:0], 8'(bi * 17), 3'd0);
        do_op(3, a[7:0], 8'(bi * 17), 3'd0);
        do_op(5, a[7:0], 8'(bi * 17), 3'd0);
        for (int p = 0; p < 4; p++) begin
          preset(p); do_op(2, a[7:0], 8'(bi * 17), 3'd0);
          preset(p); do_op(4, a[7:0], 8'(bi * 17), 3'd0);
          preset(p); do_op(6, a[7:0], 8'(bi * 17), 3'd0);
        end
      end
    end

    // R3: negate every value
    for (int a = 0; a < 256; a++) do_op(7, a[7:0], 8'h00, 3'd0);

    // R7: logic ops after presets that set C, H, V
    for (int a = 0; a < 256; a++) begin
      preset(4); do_op(8, a[7:0], 8'(a * 7 + 3), 3'd0);
      preset(5); do_op(9, a[7:0], 8'(a * 7 + 3), 3'd0);
      preset(5); do_op(10, a[7:0], 8'(a * 7 + 3), 3'd0);
      preset(4); do_op(11, a[7:0], 8'(a * 7 + 3), 3'd0);
    end

    // R8: bit transfer for every index
    for (int a = 0; a < 256; a += 5) begin
      for (int i = 0; i < 8; i++) begin
        do_op(12, a[7:0], 8'h00, i[2:0]);
        do_op(13, a[7:0] ^ 8'h5A, 8'h00, i[2:0]);
      end
    end

    // R9: interrupt enable set and clear
    do_op(14, 8'h00, 8'h00, 3'd0);
    do_op(15, 8'hFF, 8'hFF, 3'd0);
    do_op(14, 8'h12, 8'h34, 3'd0);

    // R10: each branch condition against several flag patterns
    for (int p = 0; p < 8; p++) begin
      for (int op = 16; op <= 21; op++) begin
        preset(p);
        do_op(op, 8'h00, 8'h00, 3'd0);
      end
    end

    // R11: idle cycles with every code on the bus
    preset(5);
    for (int op = 0; op < 32; op++) do_idle(op);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule